// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software through a small down-counter that must be reloaded inside a time window. The bus clock passes through a fixed divider and then a selectable power-of-two stage. Each resulting tick lowers a 7-bit counter by one. Once the watchdog is armed, two events cause a system reset request. The first is the counter's top bit falling, which is expiry. The second is a reload made too early, while the counter is still above a programmed window value.

One tick before expiry, a warning flag is raised so that software can react. If the interrupt enable is set, the interrupt output follows that flag. Software reaches the block through a plain register bus. A write is a single cycle with write enable, address and data. Read data is combinational from the address.

A reset request is a one-cycle pulse. In the same cycle the block puts every register back to its power-up value.

Top module: `wdog_window_top`

## Requirements
- R1: After reset the block is disabled. It reads 0x7F at address 0x0 (bit 7 = enable, bits 6:0 = counter) and 0x7F at address 0x4 (bits 6:0 = window, bits 12:11 = prescale select, bit 9 = interrupt enable). It reads 0 at address 0x8 (bit 0 = warning flag). Other addresses read 0, and both outputs are low.
- R2: The counter drops by one every FIXED_DIV × 2^sel bus cycles, where the select field values 0, 1, 2 and 3 give ×1, ×2, ×4 and ×8. Every counter write restarts this period.
- R3: Writing 0 to the enable bit has no effect. Only a reset clears enable.
- R4: While enabled, a decrement from 0x40 to 0x3F raises a reset request.
- R5: While enabled, a counter write with bit 6 = 0 raises a reset request. This includes the write that sets enable.
- R6: While enabled, a counter write made while the current counter is above the window raises a reset request. A write made at or below the window does not. For a write that also sets enable, the check uses the counter value from before that write.
- R7: The warning flag sets when a decrement brings the counter to 0x40, whether or not the interrupt is enabled.
- R8: Writing 0 to status bit 0 clears the flag. Writing 1 leaves it unchanged.
- R9: The interrupt enable is sticky until reset. The interrupt output is high exactly when both the flag and the enable are set.
- R10: A reset request lasts one cycle and is asserted on the clock edge that captures the offending event. On that same edge every register returns to its R1 value.
- R11: While disabled, no event raises a reset request, and the counter wraps from 0x00 to 0x7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| wd_reset_req | output | 1 | One-cycle system reset request |
| wd_irq | output | 1 | Early-warning interrupt |

## Verification
The hardest case to reach is a refresh that falls strictly inside the window. The window must be lowered first. The counter must then be brought at or below the window while still disabled, because arming with a larger counter is itself a fault. Only after that can the block be armed, and the refresh must wait until the counter has fallen below the window but not yet reached 0x40. The bench runs with a small fixed divider so these waits stay short. It computes the required number of idle cycles from the tick period, and a reference model checks every cycle on the way.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 4'h4;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 4'h8;

  // configuration register field positions
  localparam int CFG_IE_BIT    = 9;
  localparam int CFG_PSEL_LSB  = 11;
  // status register field position
  localparam int STAT_FLAG_BIT = 0;
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int FIXED_DIV = 4096,
  parameter int PSEL_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [PSEL_W-1:0] psel,
  output logic              tick
);
  localparam int FW    = (FIXED_DIV > 1) ? $clog2(FIXED_DIV) : 1;
  localparam int PMAX  = (1 << PSEL_W) - 1;
  localparam int POW_W = (PMAX > 0) ? PMAX : 1;
  localparam logic [FW-1:0] F_LAST = FW'(FIXED_DIV - 1);

  logic [FW-1:0]    fcnt_q, fcnt_d;
  logic [POW_W-1:0] pcnt_q, pcnt_d;
  logic [POW_W-1:0] term;
  logic             stage_end;

  always_comb begin
    term      = {POW_W{1'b1}} >> (PMAX - int'(psel));
    stage_end = (fcnt_q == F_LAST);
    tick      = stage_end && (pcnt_q >= term);
  end

  always_comb begin
    fcnt_d = fcnt_q;
    pcnt_d = pcnt_q;
    if (restart) begin
      fcnt_d = '0;
      pcnt_d = '0;
    end else if (stage_end) begin
      fcnt_d = '0;
      pcnt_d = tick ? '0 : pcnt_q + 1'b1;
    end else begin
      fcnt_d = fcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q <= '0;
      pcnt_q <= '0;
    end else begin
      fcnt_q <= fcnt_d;
      pcnt_q <= pcnt_d;
    end
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (FIXED_DIV > 1)) |=> !tick);

  // R2
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && (FIXED_DIV > 1)) |=> !tick);
endmodule

// File: rtl/wdog_count_core.sv
module wdog_count_core #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             wr_en_bit,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic             tick,
  input  logic [CNT_W-1:0] win,
  output logic [CNT_W-1:0] cnt,
  output logic             en,
  output logic             fault,
  output logic             warn_hit,
  output logic             rst_req
);
  localparam logic [CNT_W-1:0] EXPIRY   = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] WARN_VAL = EXPIRY + 1'b1;
  localparam logic [CNT_W-1:0] CNT_INIT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en_q, en_d;
  logic             req_q;
  logic             armed_after;

  always_comb begin
    armed_after = en_q | wr_en_bit;
    fault       = 1'b0;
    if (ctrl_wr)
      fault = armed_after && (!wr_cnt[CNT_W-1] || (cnt_q > win));
    else
      fault = en_q && tick && (cnt_q == EXPIRY);
    warn_hit = tick && !ctrl_wr && (cnt_q == WARN_VAL);
  end

  always_comb begin
    cnt_d = cnt_q;
    en_d  = en_q;
    if (fault) begin
      cnt_d = CNT_INIT;
      en_d  = 1'b0;
    end else if (ctrl_wr) begin
      cnt_d = wr_cnt;
      en_d  = armed_after;
    end else if (tick) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_INIT;
      en_q  <= 1'b0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= en_d;
      req_q <= fault;
    end
  end

  assign cnt     = cnt_q;
  assign en      = en_q;
  assign rst_req = req_q;

  // R3
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (en || rst_req));

  // R10
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R10
  req_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (!en && (cnt == CNT_INIT)));

  // R4
  expiry_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !ctrl_wr && (cnt == EXPIRY)) |=> rst_req);

  // R11
  req_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ($past(en) || $past(ctrl_wr && wr_en_bit)));
endmodule

// File: rtl/wdog_cfg_regs.sv
module wdog_cfg_regs #(
  parameter int CNT_W  = 7,
  parameter int PSEL_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              cfg_wr,
  input  logic              stat_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              warn_hit,
  output logic [CNT_W-1:0]  win,
  output logic [PSEL_W-1:0] psel,
  output logic              ie,
  output logic              flag
);
  import wdog_pkg::*;

  logic [CNT_W-1:0]  win_q, win_d;
  logic [PSEL_W-1:0] psel_q, psel_d;
  logic              ie_q, ie_d;
  logic              flag_q, flag_d;

  always_comb begin
    win_d  = win_q;
    psel_d = psel_q;
    ie_d   = ie_q;
    flag_d = flag_q;
    if (soft_clr) begin
      win_d  = {CNT_W{1'b1}};
      psel_d = '0;
      ie_d   = 1'b0;
      flag_d = 1'b0;
    end else begin
      if (cfg_wr) begin
        win_d  = wdata[CNT_W-1:0];
        psel_d = wdata[CFG_PSEL_LSB +: PSEL_W];
        ie_d   = ie_q | wdata[CFG_IE_BIT];
      end
      if (warn_hit)
        flag_d = 1'b1;
      else if (stat_wr && !wdata[STAT_FLAG_BIT])
        flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= {CNT_W{1'b1}};
      psel_q <= '0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      win_q  <= win_d;
      psel_q <= psel_d;
      ie_q   <= ie_d;
      flag_q <= flag_d;
    end
  end

  assign win  = win_q;
  assign psel = psel_q;
  assign ie   = ie_q;
  assign flag = flag_q;

  // R7
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(warn_hit));

  // R8
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && stat_wr && wdata[STAT_FLAG_BIT] && !soft_clr) |=> flag);

  // R9
  ie_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ie && !soft_clr) |=> ie);
endmodule

// File: rtl/wdog_window_top.sv
module wdog_window_top #(
  parameter int CNT_W     = 7,
  parameter int PSEL_W    = 2,
  parameter int FIXED_DIV = 4096
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_we,
  input  logic [wdog_pkg::ADDR_W-1:0]   bus_addr,
  input  logic [wdog_pkg::DATA_W-1:0]   bus_wdata,
  output logic [wdog_pkg::DATA_W-1:0]   bus_rdata,
  output logic                          wd_reset_req,
  output logic                          wd_irq
);
  import wdog_pkg::*;

  logic             ctrl_wr, cfg_wr, stat_wr;
  logic             tick, fault, warn_hit, en;
  logic [CNT_W-1:0] cnt, win;
  logic [PSEL_W-1:0] psel;
  logic             ie, flag;

  always_comb begin
    ctrl_wr = bus_we && (bus_addr == ADDR_CTRL);
    cfg_wr  = bus_we && (bus_addr == ADDR_CFG);
    stat_wr = bus_we && (bus_addr == ADDR_STAT);
  end

  wdog_tick_gen #(
    .FIXED_DIV (FIXED_DIV),
    .PSEL_W    (PSEL_W)
  ) i_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (ctrl_wr | fault),
    .psel    (psel),
    .tick    (tick)
  );

  wdog_count_core #(
    .CNT_W (CNT_W)
  ) i_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .wr_en_bit (bus_wdata[CNT_W]),
    .wr_cnt    (bus_wdata[CNT_W-1:0]),
    .tick      (tick),
    .win       (win),
    .cnt       (cnt),
    .en        (en),
    .fault     (fault),
    .warn_hit  (warn_hit),
    .rst_req   (wd_reset_req)
  );

  wdog_cfg_regs #(
    .CNT_W  (CNT_W),
    .PSEL_W (PSEL_W),
    .DATA_W (DATA_W)
  ) i_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (fault),
    .cfg_wr   (cfg_wr),
    .stat_wr  (stat_wr),
    .wdata    (bus_wdata),
    .warn_hit (warn_hit),
    .win      (win),
    .psel     (psel),
    .ie       (ie),
    .flag     (flag)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_CTRL: begin
        bus_rdata[CNT_W]       = en;
        bus_rdata[CNT_W-1:0]   = cnt;
      end
      ADDR_CFG: begin
        bus_rdata[CNT_W-1:0]                 = win;
        bus_rdata[CFG_IE_BIT]                = ie;
        bus_rdata[CFG_PSEL_LSB +: PSEL_W]    = psel;
      end
      ADDR_STAT: bus_rdata[STAT_FLAG_BIT] = flag;
      default:   bus_rdata = '0;
    endcase
  end

  assign wd_irq = ie & flag;

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_irq |-> $past(flag || warn_hit));
endmodule

// File: tb/test_wdog_window_top.sv
module test_wdog_window_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        rst_req, irq;

  int    total = 0;
  int    bad = 0;
  int    req_seen = 0;
  int    rot = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_window_top #(.FIXED_DIV(DIV)) i_wdog_window_top (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_we       (we),
    .bus_addr     (addr),
    .bus_wdata    (wdata),
    .bus_rdata    (rdata),
    .wd_reset_req (rst_req),
    .wd_irq       (irq)
  );

  // behavioural reference model
  bit       m_en, m_ie, m_flag, m_req;
  bit [6:0] m_cnt, m_win;
  bit [1:0] m_psel;
  int       phase;

  always @(posedge clk) begin : model
    bit tick, fault, en_new, set_f;
    int period;
    if (!rst_n) begin
      m_en = 0; m_cnt = 7'h7F; m_win = 7'h7F; m_psel = 0;
      m_ie = 0; m_flag = 0; m_req = 0; phase = 0;
    end else begin
      period = DIV << m_psel;
      tick   = ((phase + 1) % period) == 0;
      fault  = 0;
      en_new = m_en;
      if (we && addr == 4'h0) begin
        en_new = m_en | wdata[7];
        if (en_new && (!wdata[6] || m_cnt > m_win)) fault = 1;
      end else if (tick && m_en && m_cnt == 7'h40) begin
        fault = 1;
      end
      if (fault) begin
        m_en = 0; m_cnt = 7'h7F; m_win = 7'h7F; m_psel = 0;
        m_ie = 0; m_flag = 0; m_req = 1; phase = 0;
      end else begin
        m_req = 0;
        set_f = 0;
        if (we && addr == 4'h0) begin
          m_en = en_new; m_cnt = wdata[6:0]; phase = 0;
        end else begin
          phase++;
          if (tick) begin
            if (m_cnt == 7'h41) set_f = 1;
            m_cnt = m_cnt - 7'd1;
          end
        end
        if (we && addr == 4'h4) begin
          m_win = wdata[6:0]; m_psel = wdata[12:11]; m_ie = m_ie | wdata[9];
        end
        if (set_f) m_flag = 1;
        else if (we && addr == 4'h8 && !wdata[0]) m_flag = 0;
      end
    end
  end

  function automatic logic [31:0] model_rd(logic [3:0] a);
    case (a)
      4'h0:    return {24'h0, m_en, m_cnt};
      4'h4:    return {19'h0, m_psel, 1'b0, m_ie, 2'b00, m_win};
      4'h8:    return {31'h0, m_flag};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rst_req) req_seen++;
      check(tag, "reset request", {31'h0, rst_req}, {31'h0, m_req});
      check(tag, "interrupt", {31'h0, irq}, {31'h0, m_ie & m_flag});
      check(tag, "read data", rdata, model_rd(addr));
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      we = 1'b0;
      addr = 4'(rot * 4);
      rot = (rot + 1) % 3;
    end
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string req);
    @(posedge clk); #1;
    we = 1'b0; addr = a;
    @(negedge clk);
    check(req, "register read", rdata, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values
    tag = "R1";
    rd(4'h0, 32'h7F, "R1");
    rd(4'h4, 32'h7F, "R1");
    rd(4'h8, 32'h0, "R1");
    rd(4'hC, 32'h0, "R1");
    check("R1", "irq after reset", {31'h0, irq}, 32'h0);

    // R11 / R7: run disabled through expiry and wrap
    tag = "R11";
    wr(4'h0, 32'h45);
    idle(300);
    check("R11", "no request while disabled", req_seen, 0);
    rd(4'h8, 32'h1, "R7");

    // R8 flag clear semantics
    tag = "R8";
    wr(4'h8, 32'h1);
    rd(4'h8, 32'h1, "R8");
    wr(4'h8, 32'h0);
    rd(4'h8, 32'h0, "R8");

    // R2 prescale selections and restart on write
    tag = "R2";
    for (int p = 1; p < 4; p++) begin
      wr(4'h4, 32'h7F | (p << 11));
      wr(4'h0, 32'h60);
      idle((DIV << p) - 1);
      rd(4'h0, 32'h60, "R2");
      rd(4'h0, 32'h5F, "R2");
      idle((DIV << p) * 2);
    end

    // R3 / R9 / R4 / R10
    tag = "R3";
    wr(4'h4, 32'h7F | (1 << 9));
    wr(4'h0, 32'hFF);
    wr(4'h0, 32'h7F);
    rd(4'h0, 32'hFF, "R3");
    tag = "R9";
    wr(4'h4, 32'h7F);
    rd(4'h4, 32'h27F, "R9");
    for (int i = 0; i < 400 && !irq; i++) idle(1);
    check("R9", "irq with flag and enable", {31'h0, irq}, 32'h1);
    check("R4", "no request before expiry", req_seen, 0);
    tag = "R4";
    for (int i = 0; i < 50 && req_seen == 0; i++) idle(1);
    check("R4", "expiry request count", req_seen, 1);
    tag = "R10";
    rd(4'h0, 32'h7F, "R10");
    rd(4'h4, 32'h7F, "R10");
    rd(4'h8, 32'h0, "R10");

    // R6 window rule
    tag = "R6";
    wr(4'h4, 32'h50);
    wr(4'h0, 32'hFF);
    idle(3);
    check("R6", "arming write above window", req_seen, 2);
    wr(4'h4, 32'h50);
    wr(4'h0, 32'h50);
    wr(4'h0, 32'hFF);
    idle(3);
    check("R6", "arming write at window", req_seen, 2);
    wr(4'h0, 32'hFF);
    idle(3);
    check("R6", "early refresh", req_seen, 3);
    wr(4'h4, 32'h50);
    wr(4'h0, 32'h50);
    wr(4'h0, 32'hFF);
    base = 48 * DIV + 8;
    idle(base);
    wr(4'h0, 32'hFF);
    idle(3);
    check("R6", "refresh inside window", req_seen, 3);

    // R5 low counter writes
    tag = "R5";
    wr(4'h4, 32'h7F);
    wr(4'h0, 32'hFF);
    wr(4'h0, 32'h3F);
    idle(3);
    check("R5", "enabled write below 0x40", req_seen, 4);
    wr(4'h0, 32'hBF);
    idle(3);
    check("R5", "arming write below 0x40", req_seen, 5);
    tag = "R11";
    wr(4'h0, 32'h3F);
    idle(3);
    check("R11", "disabled write below 0x40", req_seen, 5);
    idle(10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule